// File: doc/BRIEF.md
# Serial Boot Configuration Loader

This block fetches the chip's boot-time configuration word over a one-wire serial link once the core supply is reported good. It generates its own slow shift clock by dividing the system clock. It captures one configuration bit on each rising edge of that clock, least significant bit first. It then presents the decoded fields to the rest of the chip:
- the clock-ratio select;
- the output drive-speed select;
- the enable for the request/acknowledge and response-swap handshake.

The block also holds the core in reset until the word is complete and the warm reset input is released. The cold reset `rst` is synchronous and active high. The captured word stays frozen until the next cold reset. The division ratio and the word length are parameters. Their defaults are a division by 256 and a 256-bit word.

Top module: `boot_mode_loader`

## Requirements
- R1: After cold reset `load_done` is 0, `core_rst` is 1, `mode_clk` is 0, and `ratio_x2`, `drive_sel` and `hs_en` are 0. While `supply_ok` has not been seen high, `mode_clk` stays 0 and no bit is captured.
- R2: During loading `mode_clk` has a period of DIV system clocks and is high for DIV/2 of them.
- R3: Bit k of the stream (k = 0 first) is the value of `mode_din` at the k-th rising edge of `mode_clk`, and it ends up at `mode_word[k]`. Exactly WORD_W rising edges occur per load.
- R4: `load_done` rises on the system clock edge that ends the mode clock period of the last bit. It stays high until cold reset. `mode_clk` is 0 whenever `load_done` is 1. Dropping `supply_ok` after loading has begun does not abort the load.
- R5: Once `load_done` is 1, changes on `mode_din` and `supply_ok` have no effect on `mode_word`, the decoded fields or `mode_clk`.
- R6: `drive_sel` takes word bits 14:13. Code 2'b10 (fastest) and code 2'b01 (slowest) pass through unchanged. Codes 2'b00 and 2'b11 are presented as 2'b01.
- R7: `hs_en` equals word bit 26.
- R8: Word bits 19:16 hold a ratio code, and `ratio_x2` is twice the selected ratio. Codes 0..6 give 4..10 (ratios 2 to 5 in half steps). Codes 7..10 give 12, 14, 16, 18 (ratios 6 to 9). Codes 11..15 give 4.
- R9: `core_rst` is registered. It deasserts one clock after `load_done` is high with `ext_rst` low. It reasserts one clock after `ext_rst` goes high.
- R10: The decoded fields change in the same clock as `load_done` rises. A cold reset followed by `supply_ok` starts a fresh load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high cold reset |
| supply_ok | input | 1 | Core supply stable; starts the load |
| ext_rst | input | 1 | Active-high warm reset request for the core |
| mode_din | input | 1 | Serial configuration data |
| mode_clk | output | 1 | Divided shift clock |
| load_done | output | 1 | Configuration word fully captured |
| core_rst | output | 1 | Active-high reset to the core |
| mode_word | output | WORD_W | Captured configuration word |
| ratio_x2 | output | 5 | Twice the selected clock ratio |
| drive_sel | output | 2 | Output drive-speed select |
| hs_en | output | 1 | Request/acknowledge and response-swap enable |

## Verification
The bench builds the block with DIV = 8 and WORD_W = 32. A full load then takes about 260 clocks, which makes it cheap to run sixteen separate loads, one for each ratio code, including all five out-of-range codes. The short word still covers bit 26, so every decoded field is reachable. The small divisor lets the bench measure the mode clock period and high time exactly. It also lets the bench check the one-cycle spacing between `load_done`, the field update and `core_rst` release.

// File: rtl/boot_mode_pkg.sv
`timescale 1ns/1ps
package boot_mode_pkg;
  localparam int DRV_LSB   = 13;
  localparam int DRV_W     = 2;
  localparam int HS_BIT    = 26;
  localparam int RATIO_LSB = 16;
  localparam int RATIO_CW  = 4;
  localparam int RATIO_OW  = 5;
  localparam int MIN_WORD  = HS_BIT + 1;

  typedef struct packed {
    logic [RATIO_OW-1:0] ratio_x2;
    logic [DRV_W-1:0]    drive;
    logic                hs_en;
  } boot_cfg_t;

  function automatic logic [RATIO_OW-1:0] ratio_code_x2(input logic [RATIO_CW-1:0] code);
    if (code <= 4'd6)
      return 5'd4 + {1'b0, code};
    else if (code <= 4'd10)
      return 5'd12 + {code - 4'd7, 1'b0};
    else
      return 5'd4;
  endfunction

  function automatic logic [DRV_W-1:0] drive_code(input logic [DRV_W-1:0] raw);
    return (raw == 2'b10) ? 2'b10 : 2'b01;
  endfunction
endpackage

// File: rtl/mode_clk_gen.sv
`timescale 1ns/1ps
module mode_clk_gen #(
  parameter int DIV = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mclk,
  output logic rise_stb,
  output logic wrap_stb
);
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;

  logic [CW-1:0] cnt_q;
  logic          mclk_q;
  logic          at_half;
  logic          at_end;

  assign at_half  = (cnt_q == CW'(HALF - 1));
  assign at_end   = (cnt_q == CW'(DIV - 1));
  assign rise_stb = run & at_half;
  assign wrap_stb = run & at_end;
  assign mclk     = mclk_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q  <= '0;
      mclk_q <= 1'b0;
    end else begin
      cnt_q <= at_end ? '0 : cnt_q + 1'b1;
      if (at_half)
        mclk_q <= 1'b1;
      else if (at_end)
        mclk_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mode_shifter.sv
`timescale 1ns/1ps
module mode_shifter #(
  parameter int WORD_W = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              din,
  output logic [WORD_W-1:0] word,
  output logic              full
);
  localparam int BCW = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sr_q;
  logic [BCW-1:0]    bits_q;

  assign full = (bits_q == BCW'(WORD_W));
  assign word = sr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q   <= '0;
      bits_q <= '0;
    end else if (shift_en && !full) begin
      sr_q   <= {din, sr_q[WORD_W-1:1]};
      bits_q <= bits_q + 1'b1;
    end
  end
endmodule

// File: rtl/mode_field_latch.sv
`timescale 1ns/1ps
module mode_field_latch
  import boot_mode_pkg::*;
#(
  parameter int WORD_W = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output boot_cfg_t         cfg
);
  boot_cfg_t cfg_q;
  boot_cfg_t cfg_d;

  always_comb begin
    cfg_d.ratio_x2 = ratio_code_x2(word[RATIO_LSB +: RATIO_CW]);
    cfg_d.drive    = drive_code(word[DRV_LSB +: DRV_W]);
    cfg_d.hs_en    = word[HS_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst)
      cfg_q <= '0;
    else if (load)
      cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/boot_mode_loader.sv
`timescale 1ns/1ps
module boot_mode_loader
  import boot_mode_pkg::*;
#(
  parameter int DIV    = 256,
  parameter int WORD_W = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              supply_ok,
  input  logic              ext_rst,
  input  logic              mode_din,
  output logic              mode_clk,
  output logic              load_done,
  output logic              core_rst,
  output logic [WORD_W-1:0] mode_word,
  output logic [4:0]        ratio_x2,
  output logic [1:0]        drive_sel,
  output logic              hs_en
);
  logic      run_q;
  logic      done_q;
  logic      core_rst_q;
  logic      rise_stb;
  logic      wrap_stb;
  logic      full;
  logic      finish;
  boot_cfg_t cfg;

  generate
    if (WORD_W < MIN_WORD || DIV < 4 || (DIV % 2) != 0) begin : g_bad_cfg
      initial $error("boot_mode_loader: unsupported DIV/WORD_W");
    end
  endgenerate

  mode_clk_gen #(.DIV(DIV)) clkgen_i (
    .clk      (clk),
    .rst      (rst),
    .run      (run_q),
    .mclk     (mode_clk),
    .rise_stb (rise_stb),
    .wrap_stb (wrap_stb)
  );

  mode_shifter #(.WORD_W(WORD_W)) shifter_i (
    .clk      (clk),
    .rst      (rst),
    .shift_en (rise_stb),
    .din      (mode_din),
    .word     (mode_word),
    .full     (full)
  );

  assign finish = run_q & wrap_stb & full;

  mode_field_latch #(.WORD_W(WORD_W)) fields_i (
    .clk  (clk),
    .rst  (rst),
    .load (finish),
    .word (mode_word),
    .cfg  (cfg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (!run_q && supply_ok)
        run_q <= 1'b1;
      else if (finish) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      core_rst_q <= 1'b1;
    else
      core_rst_q <= !done_q || ext_rst;
  end

  assign load_done = done_q;
  assign core_rst  = core_rst_q;
  assign ratio_x2  = cfg.ratio_x2;
  assign drive_sel = cfg.drive;
  assign hs_en     = cfg.hs_en;
endmodule

// File: rtl/boot_mode_loader_chk.sv
`timescale 1ns/1ps
module boot_mode_loader_chk #(
  parameter int WORD_W = 256
) (
  input logic              clk,
  input logic              rst,
  input logic              ext_rst,
  input logic              mode_clk,
  input logic              load_done,
  input logic              core_rst,
  input logic [WORD_W-1:0] mode_word,
  input logic [4:0]        ratio_x2,
  input logic [1:0]        drive_sel
);
  // R4
  done_sticks_chk: assert property (@(posedge clk) disable iff (rst)
    load_done |=> load_done);

  // R4
  clk_quiet_when_done_chk: assert property (@(posedge clk) disable iff (rst)
    load_done |-> !mode_clk);

  // R5
  word_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (load_done && $past(load_done)) |-> $stable(mode_word));

  // R9
  core_held_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(load_done) || $past(ext_rst)) |-> core_rst);

  // R9
  core_released_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(load_done) && !$past(ext_rst) && !$past(rst)) |-> !core_rst);

  // R6
  drive_legal_chk: assert property (@(posedge clk) disable iff (rst)
    load_done |-> (drive_sel == 2'b01 || drive_sel == 2'b10));

  // R8
  ratio_range_chk: assert property (@(posedge clk) disable iff (rst)
    load_done |-> (ratio_x2 >= 5'd4 && ratio_x2 <= 5'd18));
endmodule

bind boot_mode_loader boot_mode_loader_chk #(.WORD_W(WORD_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .ext_rst   (ext_rst),
  .mode_clk  (mode_clk),
  .load_done (load_done),
  .core_rst  (core_rst),
  .mode_word (mode_word),
  .ratio_x2  (ratio_x2),
  .drive_sel (drive_sel)
);

// File: tb/boot_mode_loader_tb_top.sv
`timescale 1ns/1ps
module boot_mode_loader_tb_top;
  localparam int DIV = 8;
  localparam int BW  = 32;
  localparam int CLK_NS = 4;

  typedef struct {
    logic [BW-1:0] word;
    logic [4:0]    ratio;
    logic [1:0]    drive;
    logic          hs;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          supply_ok = 1'b0;
  logic          ext_rst = 1'b0;
  logic          mode_din = 1'b0;
  logic          mode_clk;
  logic          load_done;
  logic          core_rst;
  logic [BW-1:0] mode_word;
  logic [4:0]    ratio_x2;
  logic [1:0]    drive_sel;
  logic          hs_en;

  int   total = 0;
  int   bad = 0;
  int   rises = 0;
  exp_t sb_q[$];

  always #(CLK_NS/2) clk = ~clk;

  boot_mode_loader #(.DIV(DIV), .WORD_W(BW)) dut_i (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .ext_rst(ext_rst),
    .mode_din(mode_din), .mode_clk(mode_clk), .load_done(load_done),
    .core_rst(core_rst), .mode_word(mode_word), .ratio_x2(ratio_x2),
    .drive_sel(drive_sel), .hs_en(hs_en)
  );

  always @(posedge mode_clk) rises++;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_ratio(input logic [3:0] c);
    case (c)
      4'd0: return 5'd4;   4'd1: return 5'd5;   4'd2: return 5'd6;
      4'd3: return 5'd7;   4'd4: return 5'd8;   4'd5: return 5'd9;
      4'd6: return 5'd10;  4'd7: return 5'd12;  4'd8: return 5'd14;
      4'd9: return 5'd16;  4'd10: return 5'd18;
      default: return 5'd4;
    endcase
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    supply_ok = 1'b0;
    ext_rst = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rises = 0;
  endtask

  // driver: pushes the expected result, then shifts the word out
  task automatic drive_load(input logic [BW-1:0] w, input bit drop_supply, input bit measure);
    exp_t e;
    realtime t0, t1, t2;
    e.word  = w;
    e.ratio = exp_ratio(w[19:16]);
    e.drive = (w[14:13] == 2'b10) ? 2'b10 : 2'b01;
    e.hs    = w[26];
    sb_q.push_back(e);
    mode_din = w[0];
    @(negedge clk);
    supply_ok = 1'b1;
    for (int i = 1; i < BW; i++) begin
      @(posedge mode_clk);
      if (measure && i == 1) t0 = $realtime;
      if (measure && i == 2) begin
        t1 = $realtime;
        @(negedge mode_clk);
        t2 = $realtime;
        chk("R2 period", 64'(int'(t1 - t0)), 64'(DIV * CLK_NS));
        chk("R2 high time", 64'(int'(t2 - t1)), 64'(DIV / 2 * CLK_NS));
      end
      #1 mode_din = w[i];
      if (drop_supply && i == 3) supply_ok = 1'b0;
    end
    @(posedge load_done);
    @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: pops and compares as each load completes
  initial begin
    forever begin
      @(posedge load_done);
      @(negedge clk);
      if (sb_q.size() == 0) begin
        chk("R4 unexpected done", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk("R3 word", 64'(mode_word), 64'(e.word));
        chk("R3 rise count", 64'(rises), 64'(BW));
        chk("R8 ratio", 64'(ratio_x2), 64'(e.ratio));
        chk("R6 drive", 64'(drive_sel), 64'(e.drive));
        chk("R7 hs_en", 64'(hs_en), 64'(e.hs));
        chk("R4 mode_clk low at done", 64'(mode_clk), 64'd0);
        chk("R9 core_rst still held", 64'(core_rst), 64'd1);
      end
    end
  end

  initial begin
    #(CLK_NS * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [BW-1:0] w;
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk("R1 load_done", 64'(load_done), 64'd0);
    chk("R1 core_rst", 64'(core_rst), 64'd1);
    chk("R1 mode_clk", 64'(mode_clk), 64'd0);
    chk("R1 fields", 64'({ratio_x2, drive_sel, hs_en}), 64'd0);
    mode_din = 1'b1;
    repeat (40) @(negedge clk);
    chk("R1 idle no rises", 64'(rises), 64'd0);
    chk("R1 idle no done", 64'(load_done), 64'd0);

    // first load with clock measurement: code 9, fastest drive, handshake on
    w = 32'hA5C3_0F5A;
    w[19:16] = 4'd9; w[14:13] = 2'b10; w[26] = 1'b1;
    drive_load(w, 1'b0, 1'b1);
    chk("R9 core_rst released", 64'(core_rst), 64'd0);
    // R5: stimulus after done has no effect
    rises = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      mode_din = ~mode_din;
      supply_ok = k[0];
    end
    @(negedge clk);
    chk("R5 word held", 64'(mode_word), 64'(w));
    chk("R5 ratio held", 64'(ratio_x2), 64'd16);
    chk("R5 no mode clock", 64'(rises), 64'd0);
    chk("R4 done held", 64'(load_done), 64'd1);
    // R9 warm reset
    ext_rst = 1'b1;
    @(negedge clk);
    chk("R9 reassert", 64'(core_rst), 64'd1);
    ext_rst = 1'b0;
    @(negedge clk);
    chk("R9 release", 64'(core_rst), 64'd0);

    // R10 cold reset clears; load with supply dropped mid-stream and warm reset held
    do_reset();
    @(negedge clk);
    chk("R10 cleared done", 64'(load_done), 64'd0);
    chk("R10 cleared fields", 64'({ratio_x2, drive_sel, hs_en}), 64'd0);
    w = 32'h1234_5678;
    w[19:16] = 4'd13; w[14:13] = 2'b00; w[26] = 1'b0;
    ext_rst = 1'b1;
    drive_load(w, 1'b1, 1'b0);
    chk("R9 held by ext_rst", 64'(core_rst), 64'd1);
    ext_rst = 1'b0;
    @(negedge clk);
    chk("R9 release after ext_rst", 64'(core_rst), 64'd0);

    // R8 every ratio code, R6 every drive code
    for (int c = 0; c < 16; c++) begin
      do_reset();
      w = {c[7:0], 8'h3C, c[3:0], c[3:0], 8'h96} ^ 32'h0F0F_F0F0;
      w[19:16] = c[3:0];
      w[14:13] = c[1:0];
      w[26] = c[2];
      drive_load(w, 1'b0, 1'b0);
    end

    repeat (5) @(negedge clk);
    chk("R3 scoreboard drained", 64'(sb_q.size()), 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule